// File: doc/BRIEF.md
# Ping-Pong Frame Transpose Buffer

This block turns a raster video stream into a column stream. Pixels arrive one line at a time, with a start-of-frame marker on the first pixel of a frame and a start-of-line marker on the first pixel of every later line. They are stored in one of two frame banks. Once a bank holds a complete frame, the block plays it back one column at a time. It walks down all lines of column 0, then all lines of column 1, and so on. A line-array light modulator needs a whole column of pixels at once, and this order gives it that.

The two banks alternate. While one completed frame is read out under the consumer's ready signal, the next frame fills the other bank. The write bank changes only on a start-of-frame marker, and only if the other bank is free. If both banks already hold complete frames, the newest one is given up. The incoming frame overwrites it, and a one-cycle dropped-frame pulse is raised. The frame size and the pixel width are parameters.

Top module: `pingpong_transpose`

## Requirements
- R1: A valid pixel with `in_sof` high is stored as line 0, column 0. A valid pixel with `in_sol` high (and `in_sof` low) goes to column 0 of the next line. Any other valid pixel goes to the next column of the same line.
- R2: A stored frame is output column by column, from column 0 to COLS-1. Within each column, `out_idx` runs from 0 to ROWS-1, and `out_data` is the pixel stored at line `out_idx`, column `out_col`.
- R3: `out_fsync` is high on the first output word of each frame (column 0, index 0) and low on every other word.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_col`, `out_idx` and `out_data` hold their values into the next cycle.
- R5: After reset, `out_valid` stays low until a complete frame has been stored. Pixels that arrive before the first `in_sof` are discarded. `out_valid` rises on the cycle after the frame's last pixel is accepted.
- R6: On `in_sof`, a completed frame in the write bank causes a bank swap if the other bank is free. Frames are then delivered in arrival order and none is lost while the consumer keeps up, because readout of one bank continues while the other bank fills.
- R7: An `in_sof` that finds both banks holding complete frames discards the newer one. The incoming frame replaces it, the older frame is still delivered in full, and `frame_dropped` is high for exactly one cycle, on the cycle after that `in_sof`.
- R8: An incomplete frame that is cut short by a new `in_sof` produces no output and raises no `frame_dropped`.
- R9: Pixels that arrive after the last pixel of a frame and before the next `in_sof` are ignored.
- R10: Reset drives `out_valid` and `frame_dropped` low and forgets both stored frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel is present |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_sol | input | 1 | Marks the first pixel of every line after the first |
| in_data | input | PW | Input pixel value |
| out_ready | input | 1 | Consumer accepts the current output word |
| out_valid | output | 1 | Output word is present |
| out_fsync | output | 1 | Marks the first word of an output frame |
| out_col | output | $clog2(COLS) | Column being output |
| out_idx | output | $clog2(ROWS) | Line index within the column |
| out_data | output | PW | Output pixel value |
| frame_dropped | output | 1 | One-cycle pulse when a complete frame is discarded |

## Verification
The bench builds the block with COLS=8, ROWS=6 and PW=14. A whole frame is then only 48 pixels, so stalled readout, back-to-back frames, frame drops and a mid-readout reset all fit in a short run. The frame is not square, so a swapped line/column address shows up as a data error. Each test pixel value encodes its frame tag, line and column, so any misplaced word can be identified.

// File: rtl/tpose_pkg.sv
package tpose_pkg;

  // Bank selector: two frame banks used alternately.
  localparam int unsigned NUM_BANKS = 2;

  // Linear address of pixel (line, col) in a bank of 'cols' pixels per line.
  function automatic int unsigned lin_addr(int unsigned line, int unsigned col,
                                           int unsigned cols);
    return line * cols + col;
  endfunction

  // The bank that is not 'b'.
  function automatic logic other_bank(logic b);
    return ~b;
  endfunction

endpackage

// File: rtl/tpose_wr_side.sv
module tpose_wr_side
  import tpose_pkg::*;
#(
  parameter int COLS = 16,
  parameter int ROWS = 12,
  parameter int AW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_sol,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          sof_evt,
  output logic          frame_done
);
  localparam int RCW = $clog2(ROWS + 1);
  localparam int CCW = $clog2(COLS + 1);

  logic           armed;
  logic [RCW-1:0] row_q, tgt_row;
  logic [CCW-1:0] col_q, tgt_col;

  // Position of the pixel currently on the input.
  always_comb begin
    if (in_sof) begin
      tgt_row = '0;
      tgt_col = '0;
    end else if (in_sol) begin
      tgt_row = row_q + 1'b1;
      tgt_col = '0;
    end else begin
      tgt_row = row_q;
      tgt_col = col_q;
    end
  end

  assign sof_evt    = in_valid && in_sof;
  assign wr_en      = in_valid && (in_sof || armed) &&
                      (tgt_row < RCW'(ROWS)) && (tgt_col < CCW'(COLS));
  assign wr_addr    = AW'(lin_addr(32'(tgt_row), 32'(tgt_col), COLS));
  assign frame_done = wr_en && (tgt_row == RCW'(ROWS - 1)) &&
                      (tgt_col == CCW'(COLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      row_q <= '0;
      col_q <= '0;
    end else if (wr_en) begin
      row_q <= tgt_row;
      col_q <= tgt_col + 1'b1;
      armed <= !frame_done;
    end
  end

  // R9: once a frame is complete, nothing is written until the next sof.
  p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!wr_en || in_sof));

  // R1: write addresses stay inside one bank.
  p_addr_in_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < COLS * ROWS));

endmodule

// File: rtl/tpose_rd_scan.sv
module tpose_rd_scan
  import tpose_pkg::*;
#(
  parameter int COLS = 16,
  parameter int ROWS = 12,
  parameter int AW   = 8,
  parameter int CW   = 4,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ready,
  output logic          active,
  output logic          fsync,
  output logic [CW-1:0] col,
  output logic [IW-1:0] idx,
  output logic [AW-1:0] addr,
  output logic          done
);
  logic first_q;
  logic beat;

  assign beat  = active && ready;
  assign done  = beat && (idx == IW'(ROWS - 1)) && (col == CW'(COLS - 1));
  assign fsync = active && first_q;
  // Line index counts fastest: consecutive beats step down one column.
  assign addr  = AW'(lin_addr(32'(idx), 32'(col), COLS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      first_q <= 1'b0;
      col     <= '0;
      idx     <= '0;
    end else if (!active) begin
      if (start) begin
        active  <= 1'b1;
        first_q <= 1'b1;
        col     <= '0;
        idx     <= '0;
      end
    end else if (beat) begin
      first_q <= 1'b0;
      if (idx == IW'(ROWS - 1)) begin
        idx <= '0;
        if (col == CW'(COLS - 1)) active <= 1'b0;
        else                      col    <= col + 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R2: inside a column the line index steps by one on each accepted word.
  p_col_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && idx != IW'(ROWS - 1)) |=>
      (idx == IW'($past(idx) + 1'b1)) && (col == $past(col)));

endmodule

// File: rtl/tpose_bank_ctrl.sv
module tpose_bank_ctrl
  import tpose_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof_evt,
  input  logic       frame_done,
  input  logic       rd_active,
  input  logic       rd_done,
  output logic       wr_sel,
  output logic       rd_start,
  output logic       rd_bank,
  output logic [1:0] bank_full,
  output logic       drop_evt,
  output logic       drop_q
);
  logic wr_bank;
  logic swap_evt;
  logic pick;

  always_comb begin
    swap_evt = sof_evt && bank_full[wr_bank] && !bank_full[other_bank(wr_bank)];
    drop_evt = sof_evt && bank_full[wr_bank] &&  bank_full[other_bank(wr_bank)];
    wr_sel   = swap_evt ? other_bank(wr_bank) : wr_bank;
    // The older frame is always the one outside the write bank.
    pick     = bank_full[other_bank(wr_bank)] ? other_bank(wr_bank) : wr_bank;
    rd_start = !rd_active && (bank_full != 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank   <= 1'b0;
      rd_bank   <= 1'b0;
      bank_full <= '0;
      drop_q    <= 1'b0;
    end else begin
      wr_bank <= wr_sel;
      drop_q  <= drop_evt;
      if (rd_start) rd_bank <= pick;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (frame_done && wr_bank == 1'(b)) bank_full[b] <= 1'b1;
        if ((rd_done && rd_bank == 1'(b)) || (drop_evt && wr_bank == 1'(b)))
          bank_full[b] <= 1'b0;
      end
    end
  end

  // R5: the read side only ever walks a bank that holds a complete frame.
  p_read_bank_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> bank_full[rd_bank]);

endmodule

// File: rtl/pingpong_transpose.sv
module pingpong_transpose
  import tpose_pkg::*;
#(
  parameter  int COLS  = 16,
  parameter  int ROWS  = 12,
  parameter  int PW    = 14,
  localparam int DEPTH = COLS * ROWS,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(COLS),
  localparam int IW    = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_sol,
  input  logic [PW-1:0] in_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_fsync,
  output logic [CW-1:0] out_col,
  output logic [IW-1:0] out_idx,
  output logic [PW-1:0] out_data,
  output logic          frame_dropped
);
  logic          wr_en, sof_evt, frame_done;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          wr_sel, rd_start, rd_bank, rd_done, drop_evt;
  logic [1:0]    bank_full;
  logic [PW-1:0] bank_q [NUM_BANKS];

  tpose_wr_side #(.COLS(COLS), .ROWS(ROWS), .AW(AW)) u_wr (
    .clk, .rst_n, .in_valid, .in_sof, .in_sol,
    .wr_en, .wr_addr, .sof_evt, .frame_done
  );

  tpose_bank_ctrl u_ctrl (
    .clk, .rst_n, .sof_evt, .frame_done,
    .rd_active(out_valid), .rd_done,
    .wr_sel, .rd_start, .rd_bank, .bank_full, .drop_evt,
    .drop_q(frame_dropped)
  );

  tpose_rd_scan #(.COLS(COLS), .ROWS(ROWS), .AW(AW), .CW(CW), .IW(IW)) u_rd (
    .clk, .rst_n, .start(rd_start), .ready(out_ready),
    .active(out_valid), .fsync(out_fsync), .col(out_col), .idx(out_idx),
    .addr(rd_addr), .done(rd_done)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_sel == 1'(b)) mem[wr_addr] <= in_data;
    end
    assign bank_q[b] = mem[rd_addr];
  end

  assign out_data = bank_q[rd_bank];

  // R4: a stalled word is held unchanged.
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_col) && $stable(out_idx) && $stable(out_data)));

  // R6: the bank being read is never written.
  p_no_write_into_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(out_valid && rd_bank == wr_sel));

  // R7: a drop pulse follows an input start-of-frame.
  p_drop_on_sof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_dropped |-> $past(in_valid && in_sof));

  // R3: every readout begins with the frame-sync word.
  p_first_word_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_fsync);

endmodule

// File: tb/pingpong_transpose_test.sv
`timescale 1ns/1ps
module pingpong_transpose_test;
  localparam int COLS = 8;
  localparam int ROWS = 6;
  localparam int PW   = 14;
  localparam int CW   = $clog2(COLS);
  localparam int IW   = $clog2(ROWS);

  // Frame table: {lose_prev[11], drain[10], tail[9], gaps[8], ready_mode[7:6], tag[5:0]}
  // ready_mode: 0 always ready, 1 ready two cycles of three, 2 never ready.
  localparam logic [11:0] VEC [5] = '{
    12'h401,  // R6 plain frame, consumer keeps up
    12'h742,  // R4 R9 gaps, throttled consumer, trailing junk line
    12'h083,  // R4 stalled readout begins
    12'h084,  // R6 swap while other bank is held
    12'h885   // R7 both banks full: previous frame dropped
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, in_valid, in_sof, in_sol, out_ready;
  logic [PW-1:0] in_data;
  logic          out_valid, out_fsync, frame_dropped;
  logic [CW-1:0] out_col;
  logic [IW-1:0] out_idx;
  logic [PW-1:0] out_data;

  pingpong_transpose #(.COLS(COLS), .ROWS(ROWS), .PW(PW)) uut (
    .clk, .rst_n, .in_valid, .in_sof, .in_sol, .in_data, .out_ready,
    .out_valid, .out_fsync, .out_col, .out_idx, .out_data, .frame_dropped
  );

  function automatic logic [PW-1:0] pix(int tag, int r, int c);
    return {6'(tag), 4'(r), 4'(c)};
  endfunction

  int exp_ids [64];
  int exp_wr = 0;
  int exp_rd = 0, exp_c = 0, exp_i = 0;
  int n_drop = 0, cyc = 0, ready_mode = 0;
  int m_chk = 0, m_bad = 0, c_chk = 0, c_bad = 0;
  bit finished = 0;

  // Output monitor and consumer.
  bit            have_stall = 0;
  logic [CW-1:0] st_col;
  logic [IW-1:0] st_idx;
  logic [PW-1:0] st_data;
  logic [PW-1:0] want;
  bit            rdy;

  initial out_ready = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n !== 1'b1) begin
      exp_rd = exp_wr; exp_c = 0; exp_i = 0;
      have_stall = 0; out_ready = 1'b0;
    end else begin
      if (have_stall) begin
        c_chk++;
        if (!out_valid || out_col !== st_col || out_idx !== st_idx || out_data !== st_data) begin
          c_bad++;
          $display("FAIL R4 stall hold: act col=%0d idx=%0d data=%h v=%0b exp col=%0d idx=%0d data=%h",
                   out_col, out_idx, out_data, out_valid, st_col, st_idx, st_data);
        end
      end
      if (frame_dropped) n_drop++;
      rdy = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (cyc % 3 != 0) : 1'b0;
      out_ready = rdy;
      have_stall = out_valid && !rdy;
      st_col = out_col; st_idx = out_idx; st_data = out_data;
      if (out_valid && rdy) begin
        c_chk++;
        if (exp_rd >= exp_wr) begin
          c_bad++;
          $display("FAIL R6 unexpected word: act col=%0d idx=%0d data=%h exp none",
                   out_col, out_idx, out_data);
        end else begin
          want = pix(exp_ids[exp_rd], exp_i, exp_c);
          if (32'(out_col) != exp_c || 32'(out_idx) != exp_i) begin
            c_bad++;
            $display("FAIL R2 position: act col=%0d idx=%0d exp col=%0d idx=%0d",
                     out_col, out_idx, exp_c, exp_i);
          end
          if (out_data !== want) begin
            c_bad++;
            $display("FAIL R1 data: act %h exp %h", out_data, want);
          end
          if (out_fsync !== (exp_c == 0 && exp_i == 0)) begin
            c_bad++;
            $display("FAIL R3 fsync: act %0b exp %0b", out_fsync, (exp_c == 0 && exp_i == 0));
          end
          exp_i++;
          if (exp_i == ROWS) begin
            exp_i = 0; exp_c++;
            if (exp_c == COLS) begin exp_c = 0; exp_rd++; end
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    m_chk++;
    if (!ok) begin
      m_bad++;
      $display("FAIL %s: act %0d exp %0d", req, act, expv);
    end
  endtask

  task automatic push(int tag);
    exp_ids[exp_wr] = tag;
    exp_wr++;
  endtask

  task automatic send_frame(int tag, int rows, bit gaps, bit tail);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (r == 0 && c == 0);
        in_sol   = (c == 0 && r != 0);
        in_data  = pix(tag, r, c);
        if (gaps && (r + c) % 3 == 0) begin
          @(negedge clk);
          in_valid = 1'b0;
        end
      end
    end
    if (tail) begin
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b0; in_sol = (c == 0); in_data = '1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
  endtask

  task automatic wait_drain();
    int n = 0;
    while ((exp_rd != exp_wr || out_valid) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, "R6 all queued frames delivered", exp_rd, exp_wr);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", m_chk + c_chk, m_bad + c_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      m_chk++; m_bad++;
      $display("FAIL watchdog: act running exp finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
    chk(frame_dropped == 1'b0, "R10 reset frame_dropped", frame_dropped, 0);
    rst_n = 1'b1;

    // R5: pixels ahead of the first sof are discarded.
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_sol = (k % COLS == 0); in_data = 14'h1555;
    end
    @(negedge clk); in_valid = 1'b0; in_sol = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 no output before a full frame", out_valid, 0);
    end

    // R5 / R3: output rises on the cycle after the last pixel, with sync.
    push(7);
    send_frame(7, ROWS, 1'b0, 1'b0);
    chk(out_valid == 1'b0, "R5 not yet valid after last pixel", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 valid one cycle later", out_valid, 1);
    chk(out_fsync == 1'b1, "R3 first word carries sync", out_fsync, 1);
    wait_drain();

    for (int i = 0; i < 5; i++) begin
      ready_mode = int'(VEC[i][7:6]);
      if (i == 4) chk(n_drop == 0, "R7 no drop before both banks fill", n_drop, 0);
      if (VEC[i][11]) exp_wr--;
      push(int'(VEC[i][5:0]));
      send_frame(int'(VEC[i][5:0]), ROWS, VEC[i][8], VEC[i][9]);
      if (VEC[i][10]) wait_drain();
    end
    repeat (2) @(negedge clk);
    chk(n_drop == 1, "R7 exactly one drop pulse", n_drop, 1);
    ready_mode = 0;
    wait_drain();

    // R8: a cut-short frame is discarded silently.
    send_frame(9, 2, 1'b0, 1'b0);
    push(10);
    send_frame(10, ROWS, 1'b0, 1'b0);
    wait_drain();
    chk(n_drop == 1, "R8 restart raises no drop", n_drop, 1);

    // R10: reset during a stalled readout.
    ready_mode = 2;
    push(11);
    send_frame(11, ROWS, 1'b0, 1'b0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R10 readout pending before reset", out_valid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid cleared by reset", out_valid, 0);
    chk(frame_dropped == 1'b0, "R10 frame_dropped cleared by reset", frame_dropped, 0);
    @(negedge clk);
    rst_n = 1'b1;
    ready_mode = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 stored frames forgotten", out_valid, 0);
    end
    push(12);
    send_frame(12, ROWS, 1'b1, 1'b0);
    wait_drain();

    finished = 1;
    summary();
    $finish;
  end

endmodule